// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulate Unit

This block is a two-stage pipelined integer datapath that multiplies packed elements of two 32-bit operands, sums the products and adds them to a 32-bit accumulator input. A mode input picks one of two forms. The quad form pairs the four bytes of A with the four bytes of B. The pair form pairs the two 16-bit halves of A with two bytes of B, and a half-select input decides which two bytes are used. Each operand carries its own 2-bit kind code, which sets element width and signedness, so sign or zero extension is chosen per operand.

Operations enter through a valid/ready handshake and leave through a valid/ready handshake. A transfer happens on a rising edge where valid and ready are both high. The pipeline advances as a whole: `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds still and no new operation is accepted. A kind combination that does not fit the chosen form is not computed: it travels through the pipeline and comes out flagged as illegal with a zero result.

Top module: `dpacc_unit`

## Requirements
- R1: Quad form (`in_pair`=0): result = acc + sum over i=0..3 of A byte i times B byte i, where byte i is bits [8i+7:8i] of its operand.
- R2: Pair form (`in_pair`=1): A half j is bits [16j+15:16j]; with `in_hi`=0 half 0 pairs with B byte 2 and half 1 with B byte 3; with `in_hi`=1 half 0 pairs with B byte 0 and half 1 with B byte 1; result = acc + both products.
- R3: Kind codes are 0 unsigned byte, 1 signed byte, 2 signed halfword, 3 unsigned halfword; an element is sign-extended when its operand kind is signed and zero-extended otherwise, independently for A and B.
- R4: Quad form needs both kinds to be byte kinds (0 or 1); pair form needs an A halfword kind (2 or 3) and a B byte kind (0 or 1); any other combination gives `out_illegal`=1 and `out_result`=0.
- R5: The sum wraps modulo 2^32 with no saturation.
- R6: With `out_ready` high, an operation accepted on edge k gives `out_valid` after edge k+1, and one operation per cycle is accepted.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the output fields stay unchanged.
- R8: A synchronous active-high reset clears `out_valid` and leaves `in_ready` high; operations in flight are dropped.
- R9: `out_variant` = {A signed, B signed}, where a kind is signed when its code is 1 or 2 (00 uu, 01 us, 10 su, 11 ss).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this edge when valid |
| in_pair | input | 1 | 0 quad byte form, 1 pair halfword form |
| in_hi | input | 1 | Pair form byte select (0 bytes 2,3; 1 bytes 0,1) |
| in_a_kind | input | 2 | Kind code of operand A |
| in_b_kind | input | 2 | Kind code of operand B |
| in_a | input | 32 | Packed operand A |
| in_b | input | 32 | Packed operand B |
| in_acc | input | 32 | Accumulator addend |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 32 | Wrapped sum, zero when illegal |
| out_illegal | output | 1 | Kind combination rejected |
| out_variant | output | 2 | Signedness variant of the operation |

## Verification
The hardest situation to reach is an operation sitting in the output register under back-pressure while a second operation waits in stage 1 and a third is being offered, since only then does the frozen pipeline have to keep two results intact. The stimulus drops `out_ready` in about a third of random cycles while offering operations in three of four, so stalls with a full pipeline happen often, and a scoreboard keyed on handshakes catches any lost or duplicated result. Directed cases add a long stall with a single operation, a reset with work in flight, all-ones operands in each signedness variant, an accumulator that wraps, the two byte selections on distinguishable bytes, and each illegal kind combination.

// File: rtl/dpacc_pkg.sv
package dpacc_pkg;
  typedef enum logic [1:0] {
    KIND_U8  = 2'd0,
    KIND_S8  = 2'd1,
    KIND_S16 = 2'd2,
    KIND_U16 = 2'd3
  } kind_e;

  function automatic logic kind_is_byte(input logic [1:0] k);
    return (k == KIND_U8) || (k == KIND_S8);
  endfunction

  function automatic logic kind_is_signed(input logic [1:0] k);
    return (k == KIND_S8) || (k == KIND_S16);
  endfunction
endpackage

// File: rtl/dpacc_decode.sv
module dpacc_decode
  import dpacc_pkg::*;
(
  input  logic       pair_mode,
  input  logic [1:0] a_kind,
  input  logic [1:0] b_kind,
  output logic       illegal,
  output logic       a_signed,
  output logic       b_signed
);
  logic a_fits;
  logic b_fits;

  always_comb begin
    // A must be a byte kind in quad form and a halfword kind in pair form
    a_fits   = pair_mode ? !kind_is_byte(a_kind) : kind_is_byte(a_kind);
    b_fits   = kind_is_byte(b_kind);
    illegal  = !(a_fits && b_fits);
    a_signed = kind_is_signed(a_kind);
    b_signed = kind_is_signed(b_kind);
  end
endmodule

// File: rtl/dpacc_mul_stage.sv
module dpacc_mul_stage #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter int ACC_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          adv,
  input  logic                          in_valid,
  input  logic                          pair_mode,
  input  logic                          hi_sel,
  input  logic                          a_signed,
  input  logic                          b_signed,
  input  logic                          illegal,
  input  logic [LANES*BYTE_W-1:0]       opa,
  input  logic [LANES*BYTE_W-1:0]       opb,
  input  logic [ACC_W-1:0]              acc,
  output logic                          s1_valid,
  output logic [LANES-1:0][ACC_W-1:0]   s1_prod,
  output logic [ACC_W-1:0]              s1_acc,
  output logic                          s1_illegal,
  output logic [1:0]                    s1_variant
);
  localparam int HALVES = LANES / 2;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int XW     = HALF_W + 1;
  localparam int YW     = BYTE_W + 1;
  localparam int PW     = XW + YW;

  logic [LANES-1:0][ACC_W-1:0] prod_next;
  logic                        s1_pair;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_W-1:0]     qa, qb, pb;
    logic [HALF_W-1:0]     ph;
    logic signed [XW-1:0]  x;
    logic signed [YW-1:0]  y;
    logic signed [PW-1:0]  p;

    assign qa = opa[i*BYTE_W +: BYTE_W];
    assign qb = opb[i*BYTE_W +: BYTE_W];

    if (i < HALVES) begin : g_half
      assign ph = opa[i*HALF_W +: HALF_W];
      // low select pairs with the upper byte pair, high select with the lower one
      assign pb = hi_sel ? opb[i*BYTE_W +: BYTE_W]
                         : opb[(i+HALVES)*BYTE_W +: BYTE_W];
    end else begin : g_idle
      assign ph = '0;
      assign pb = '0;
    end

    always_comb begin
      if (pair_mode) begin
        x = {a_signed & ph[HALF_W-1], ph};
        y = {b_signed & pb[BYTE_W-1], pb};
      end else begin
        x = {{(BYTE_W+1){a_signed & qa[BYTE_W-1]}}, qa};
        y = {b_signed & qb[BYTE_W-1], qb};
      end
    end

    assign p = x * y;
    assign prod_next[i] = {{(ACC_W-PW){p[PW-1]}}, p};
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else if (adv) s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_prod    <= prod_next;
      s1_acc     <= acc;
      s1_illegal <= illegal;
      s1_variant <= {a_signed, b_signed};
      s1_pair    <= pair_mode;
    end
  end

  // pair form leaves the unused upper lanes at zero
  assert_pair_lane_R2: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_pair) |-> (s1_prod[LANES-1] == '0));
endmodule

// File: rtl/dpacc_sum_stage.sv
module dpacc_sum_stage #(
  parameter int LANES = 4,
  parameter int ACC_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adv,
  input  logic                        s1_valid,
  input  logic [LANES-1:0][ACC_W-1:0] s1_prod,
  input  logic [ACC_W-1:0]            s1_acc,
  input  logic                        s1_illegal,
  input  logic [1:0]                  s1_variant,
  output logic                        out_valid,
  output logic [ACC_W-1:0]            out_result,
  output logic                        out_illegal,
  output logic [1:0]                  out_variant
);
  logic [ACC_W-1:0] total;

  always_comb begin
    total = s1_acc;
    for (int k = 0; k < LANES; k++) total = total + s1_prod[k];
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (adv) out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_result  <= s1_illegal ? '0 : total;
      out_illegal <= s1_illegal;
      out_variant <= s1_variant;
    end
  end

  assert_illegal_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_result == '0));
endmodule

// File: rtl/dpacc_unit.sv
module dpacc_unit #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_pair,
  input  logic                     in_hi,
  input  logic [1:0]               in_a_kind,
  input  logic [1:0]               in_b_kind,
  input  logic [LANES*BYTE_W-1:0]  in_a,
  input  logic [LANES*BYTE_W-1:0]  in_b,
  input  logic [ACC_W-1:0]         in_acc,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [ACC_W-1:0]         out_result,
  output logic                     out_illegal,
  output logic [1:0]               out_variant
);
  logic                        illegal, a_signed, b_signed;
  logic                        adv;
  logic                        s1_valid, s1_illegal;
  logic [LANES-1:0][ACC_W-1:0] s1_prod;
  logic [ACC_W-1:0]            s1_acc;
  logic [1:0]                  s1_variant;

  // whole pipeline moves when the output slot is free or being drained
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  dpacc_decode u_dec (
    .pair_mode (in_pair),
    .a_kind    (in_a_kind),
    .b_kind    (in_b_kind),
    .illegal   (illegal),
    .a_signed  (a_signed),
    .b_signed  (b_signed)
  );

  dpacc_mul_stage #(.BYTE_W(BYTE_W), .LANES(LANES), .ACC_W(ACC_W)) u_mul (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .in_valid   (in_valid),
    .pair_mode  (in_pair),
    .hi_sel     (in_hi),
    .a_signed   (a_signed),
    .b_signed   (b_signed),
    .illegal    (illegal),
    .opa        (in_a),
    .opb        (in_b),
    .acc        (in_acc),
    .s1_valid   (s1_valid),
    .s1_prod    (s1_prod),
    .s1_acc     (s1_acc),
    .s1_illegal (s1_illegal),
    .s1_variant (s1_variant)
  );

  dpacc_sum_stage #(.LANES(LANES), .ACC_W(ACC_W)) u_sum (
    .clk         (clk),
    .rst         (rst),
    .adv         (adv),
    .s1_valid    (s1_valid),
    .s1_prod     (s1_prod),
    .s1_acc      (s1_acc),
    .s1_illegal  (s1_illegal),
    .s1_variant  (s1_variant),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal),
    .out_variant (out_variant)
  );

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
      && $stable(out_illegal) && $stable(out_variant)));

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/sim_dpacc_unit.sv
module sim_dpacc_unit;
  typedef struct {
    logic [31:0] res;
    logic        ill;
    logic [1:0]  vr;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_pair = 1'b0, in_hi = 1'b0, out_ready = 1'b1;
  logic [1:0]  in_a_kind = 2'd0, in_b_kind = 2'd0;
  logic [31:0] in_a = '0, in_b = '0, in_acc = '0;
  logic        in_ready, out_valid, out_illegal;
  logic [31:0] out_result;
  logic [1:0]  out_variant;
  string       cur_tag = "R1";

  int errors = 0;
  int checks = 0;
  exp_t q[$];
  logic        prev_stall = 1'b0;
  logic [31:0] prev_res;
  logic        prev_ill;
  logic [1:0]  prev_vr;

  always #4 clk = ~clk;

  dpacc_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pair(in_pair), .in_hi(in_hi), .in_a_kind(in_a_kind), .in_b_kind(in_b_kind),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal),
    .out_variant(out_variant)
  );

  function automatic int ext8(input logic [7:0] v, input bit s);
    return s ? {{24{v[7]}}, v} : {24'b0, v};
  endfunction

  function automatic int ext16(input logic [15:0] v, input bit s);
    return s ? {{16{v[15]}}, v} : {16'b0, v};
  endfunction

  function automatic exp_t model(input bit pair, input bit hi, input logic [1:0] ak,
      input logic [1:0] bk, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] c, input string tag);
    exp_t e;
    bit sa, sb, legal;
    int sum;
    sa = (ak == 2'd1) || (ak == 2'd2);
    sb = (bk == 2'd1) || (bk == 2'd2);
    legal = pair ? ((ak >= 2'd2) && (bk <= 2'd1)) : ((ak <= 2'd1) && (bk <= 2'd1));
    sum = c;
    if (!pair) begin
      for (int i = 0; i < 4; i++) sum += ext8(a[8*i +: 8], sa) * ext8(b[8*i +: 8], sb);
    end else begin
      for (int j = 0; j < 2; j++)
        sum += ext16(a[16*j +: 16], sa) * ext8(b[8*(hi ? j : j + 2) +: 8], sb);
    end
    e.res = legal ? sum : 32'd0;
    e.ill = !legal;
    e.vr  = {sa, sb};
    e.tag = tag;
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: evaluates handshakes between edges
  always @(negedge clk) begin
    if (rst) begin
      q.delete();
      prev_stall = 1'b0;
    end else begin
      if (prev_stall && out_valid) begin
        check("R7", {out_illegal, out_variant, out_result[28:0]},
              {prev_ill, prev_vr, prev_res[28:0]}, "held fields");
        check("R7", out_result, prev_res, "held result");
      end
      if (out_valid && !out_ready) check("R7", {31'd0, in_ready}, 32'd0, "in_ready under stall");
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check("R6", 32'd1, 32'd0, "unexpected result");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.tag, out_result, e.res, "result");
          check(e.ill ? "R4" : e.tag, {31'd0, out_illegal}, {31'd0, e.ill}, "illegal flag");
          check("R9", {30'd0, out_variant}, {30'd0, e.vr}, "variant");
        end
      end
      if (in_valid && in_ready)
        q.push_back(model(in_pair, in_hi, in_a_kind, in_b_kind, in_a, in_b, in_acc, cur_tag));
      prev_stall = out_valid && !out_ready;
      prev_res = out_result;
      prev_ill = out_illegal;
      prev_vr  = out_variant;
    end
  end

  task automatic send(input bit pair, input bit hi, input logic [1:0] ak,
      input logic [1:0] bk, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] c, input string tag);
    bit acc_ok;
    in_pair = pair; in_hi = hi; in_a_kind = ak; in_b_kind = bk;
    in_a = a; in_b = b; in_acc = c; cur_tag = tag; in_valid = 1'b1;
    do begin
      @(negedge clk);
      acc_ok = in_ready;
      @(posedge clk);
      #1;
    end while (!acc_ok);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got hung expected done");
    report();
  end

  initial begin
    void'($urandom(32'h5eed_0c1a));
    idle(3);
    @(negedge clk);
    check("R8", {30'd0, out_valid, in_ready}, 32'd1, "reset state");
    @(posedge clk);
    #1 rst = 1'b0;

    // R1 quad unsigned and signed, R3 independent extension
    send(0, 0, 2'd0, 2'd0, 32'h04030201, 32'h08070605, 32'd10, "R1");
    send(0, 0, 2'd1, 2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, "R3");
    send(0, 0, 2'd0, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, "R3");
    send(0, 0, 2'd1, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, "R3");
    send(0, 0, 2'd0, 2'd1, 32'h80808080, 32'h7F7F7F7F, 32'd5, "R3");
    // R5 wrap past the top
    send(0, 0, 2'd0, 2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFF0, "R5");
    send(0, 0, 2'd1, 2'd1, 32'h7F7F7F7F, 32'h7F7F7F7F, 32'h7FFFFFFF, "R5");
    // R2 byte selection with distinct bytes
    send(1, 0, 2'd3, 2'd0, 32'h00030002, 32'h40300201, 32'd0, "R2");
    send(1, 1, 2'd3, 2'd0, 32'h00030002, 32'h40300201, 32'd0, "R2");
    send(1, 0, 2'd2, 2'd1, 32'h8000FFFF, 32'h80FF0102, 32'd7, "R2");
    send(1, 1, 2'd2, 2'd0, 32'h8000FFFF, 32'hFF7F0000, 32'd0, "R3");
    // R4 illegal combinations
    send(0, 0, 2'd2, 2'd0, 32'h01010101, 32'h01010101, 32'd9, "R4");
    send(0, 0, 2'd0, 2'd3, 32'h01010101, 32'h01010101, 32'd9, "R4");
    send(1, 0, 2'd0, 2'd0, 32'h01010101, 32'h01010101, 32'd9, "R4");
    send(1, 1, 2'd3, 2'd2, 32'h01010101, 32'h01010101, 32'd9, "R4");
    idle(4);

    // R6 latency with ready high
    send(0, 0, 2'd0, 2'd0, 32'h1, 32'h1, 32'd0, "R6");
    @(negedge clk);
    check("R6", {31'd0, out_valid}, 32'd0, "valid one edge after accept");
    @(negedge clk);
    check("R6", {31'd0, out_valid}, 32'd1, "valid two edges after accept");
    idle(3);

    // R7 long stall with one result waiting
    out_ready = 1'b0;
    send(1, 1, 2'd2, 2'd1, 32'h12345678, 32'h9ABCDEF0, 32'd3, "R7");
    idle(6);
    @(negedge clk);
    check("R7", {30'd0, out_valid, in_ready}, 32'd2, "stalled handshake");
    @(posedge clk);
    #1 out_ready = 1'b1;
    idle(3);

    // R8 reset with work in flight
    out_ready = 1'b0;
    send(0, 0, 2'd1, 2'd0, 32'h11111111, 32'h22222222, 32'd1, "R8");
    idle(2);
    rst = 1'b1;
    idle(2);
    @(negedge clk);
    check("R8", {30'd0, out_valid, in_ready}, 32'd1, "reset mid-flight");
    @(posedge clk);
    #1 rst = 1'b0;
    out_ready = 1'b1;
    idle(2);

    // random traffic with back-pressure
    for (int n = 0; n < 4000; n++) begin
      bit pr;
      pr = $urandom_range(1, 0) == 1;
      in_pair = pr;
      in_hi = $urandom_range(1, 0) == 1;
      if ($urandom_range(9, 0) < 8) begin
        in_a_kind = pr ? 2'($urandom_range(3, 2)) : 2'($urandom_range(1, 0));
        in_b_kind = 2'($urandom_range(1, 0));
      end else begin
        in_a_kind = 2'($urandom_range(3, 0));
        in_b_kind = 2'($urandom_range(3, 0));
      end
      in_a = $urandom();
      in_b = $urandom();
      in_acc = $urandom();
      cur_tag = pr ? "R2" : "R1";
      in_valid = $urandom_range(3, 0) != 0;
      out_ready = $urandom_range(9, 0) < 7;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    idle(6);
    @(negedge clk);
    check("R6", q.size(), 32'd0, "results left over");
    report();
  end
endmodule